// File: doc/BRIEF.md
# Dual-Modulus Prescaler Feedback Divider

This block divides a fast clock by a programmable integer N for the feedback path of a phase-locked loop. A prescaler divides by either P or P+1. A swallow counter holds the prescaler at P+1 for the first A prescaler cycles of each output period. A main counter ends the period after B prescaler cycles. The total ratio is therefore N = P·B + A. P is chosen from five powers of two by a small select code.

The configuration (select code, A, B) is sampled only at the edge that closes an output period. Software can therefore change it at any time without producing a short or merged period. An illegal configuration raises an error flag and silences the output until a legal one is sampled. The output is a pulse one input clock wide.

Top module: `dm_fb_divider`

## Requirements
- R1: For a legal configuration, consecutive output pulses are exactly N = P·B + A input cycles apart.
- R2: The select code `p_sel` maps 0,1,2,3,4 to P = 2,4,8,16,32. The codes 5 to 7 are illegal and raise `cfg_err`.
- R3: With A = 0 the prescaler stays at P for the whole period, and the pulse spacing is P·B.
- R4: A configuration with B = 0 or B = 2 is illegal. B = 1 and any B ≥ 3 pass this rule.
- R5: A configuration with A ≥ B is illegal.
- R6: Configuration inputs are sampled only at a period boundary. A change made inside a period leaves that period at its old length. The period that is running when an illegal value is sampled still ends with its pulse, in the same cycle that `cfg_err` rises.
- R7: While an illegal configuration is active, `cfg_err` stays high and `div_pulse` stays low. After a legal configuration is sampled, `cfg_err` falls and the first pulse follows exactly N cycles later.
- R8: `div_pulse` is never high for two consecutive cycles.
- R9: During synchronous reset, `div_pulse` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| p_sel | input | 3 | Prescaler modulus select code (P = 2 shifted left by the code) |
| a_cfg | input | 6 | Swallow count A |
| b_cfg | input | 13 | Main count B |
| div_pulse | output | 1 | One-cycle divided output pulse |
| cfg_err | output | 1 | High while the sampled configuration is illegal |

## Verification
The boundary edge that closes a legal period is also the edge that samples the next configuration. If that configuration is illegal, the final pulse of the old period and the rise of the error flag fall in the same cycle. The bench provokes this by writing an illegal value while a legal period runs. It then expects the pulse and the flag together at the first cycle the flag is seen, and no pulse at all after that. The reverse case is also covered. The edge that samples a legal value after an illegal one lowers the flag without a pulse, and the bench times the first new pulse from that edge.

// File: rtl/dmfd_pkg.sv
package dmfd_pkg;

  // Main-count legality: B must be 1 or at least 3, and must exceed A.
  function automatic logic counts_legal(input int unsigned b, input int unsigned a);
    return ((b >= 32'd3) || (b == 32'd1)) && (b > a);
  endfunction

endpackage

// File: rtl/dmfd_cfg_check.sv
module dmfd_cfg_check #(
  parameter int unsigned A_W       = 6,
  parameter int unsigned B_W       = 13,
  parameter int unsigned P_LOG_MAX = 5,
  parameter int unsigned PSEL_W    = 3,
  parameter int unsigned PC_W      = 6
) (
  input  logic [PSEL_W-1:0] p_sel,
  input  logic [A_W-1:0]    a_cfg,
  input  logic [B_W-1:0]    b_cfg,
  output logic              legal,
  output logic [PC_W-1:0]   p_mod
);

  logic sel_ok;

  // Decode the select code into the base modulus P = 2^(code+1).
  always_comb begin
    p_mod  = PC_W'(2);
    sel_ok = 1'b0;
    for (int i = 0; i < int'(P_LOG_MAX); i++) begin
      if (p_sel == PSEL_W'(i)) begin
        p_mod  = PC_W'(1) << (i + 1);
        sel_ok = 1'b1;
      end
    end
  end

  assign legal = sel_ok && dmfd_pkg::counts_legal(32'(b_cfg), 32'(a_cfg));

endmodule

// File: rtl/dmfd_prescaler.sv
module dmfd_prescaler #(
  parameter int unsigned PC_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] reload_mod,
  output logic            tc
);

  logic [PC_W-1:0] pc;

  assign tc = (pc == '0);

  // Down-counter: each prescaler cycle lasts reload_mod input cycles.
  always_ff @(posedge clk) begin
    if (rst)     pc <= '0;
    else if (tc) pc <= reload_mod - PC_W'(1);
    else         pc <= pc - PC_W'(1);
  end

endmodule

// File: rtl/dmfd_counters.sv
module dmfd_counters #(
  parameter int unsigned A_W  = 6,
  parameter int unsigned B_W  = 13,
  parameter int unsigned PC_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tc,
  input  logic [A_W-1:0]  a_cfg,
  input  logic [B_W-1:0]  b_cfg,
  input  logic [PC_W-1:0] p_new,
  input  logic [PC_W-1:0] p_act,
  output logic            boundary,
  output logic [PC_W-1:0] reload_mod
);

  logic [A_W-1:0] a_cnt;   // P+1 cycles left, current one included
  logic [B_W-1:0] b_cnt;   // prescaler cycles left, current one included

  assign boundary = tc && (b_cnt <= B_W'(1));

  always_comb begin
    if (boundary)
      reload_mod = (a_cfg != '0) ? p_new + PC_W'(1) : p_new;
    else
      reload_mod = (a_cnt > A_W'(1)) ? p_act + PC_W'(1) : p_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt <= '0;
      b_cnt <= '0;
    end else if (boundary) begin
      a_cnt <= a_cfg;
      b_cnt <= b_cfg;
    end else if (tc) begin
      b_cnt <= b_cnt - B_W'(1);
      if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
    end
  end

endmodule

// File: rtl/dm_fb_divider.sv
module dm_fb_divider #(
  parameter int unsigned A_W       = 6,
  parameter int unsigned B_W       = 13,
  parameter int unsigned P_LOG_MAX = 5,
  localparam int unsigned PSEL_W   = $clog2(P_LOG_MAX),
  localparam int unsigned PC_W     = P_LOG_MAX + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PSEL_W-1:0] p_sel,
  input  logic [A_W-1:0]    a_cfg,
  input  logic [B_W-1:0]    b_cfg,
  output logic              div_pulse,
  output logic              cfg_err
);

  logic            new_legal;
  logic [PC_W-1:0] new_p;
  logic [PC_W-1:0] p_act;
  logic            legal_act;
  logic            pre_tc;
  logic            boundary;
  logic [PC_W-1:0] reload_mod;

  dmfd_cfg_check #(.A_W(A_W), .B_W(B_W), .P_LOG_MAX(P_LOG_MAX), .PSEL_W(PSEL_W), .PC_W(PC_W)) u_chk (
    .p_sel (p_sel),
    .a_cfg (a_cfg),
    .b_cfg (b_cfg),
    .legal (new_legal),
    .p_mod (new_p)
  );

  dmfd_prescaler #(.PC_W(PC_W)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .reload_mod (reload_mod),
    .tc         (pre_tc)
  );

  dmfd_counters #(.A_W(A_W), .B_W(B_W), .PC_W(PC_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tc         (pre_tc),
    .a_cfg      (a_cfg),
    .b_cfg      (b_cfg),
    .p_new      (new_p),
    .p_act      (p_act),
    .boundary   (boundary),
    .reload_mod (reload_mod)
  );

  // The pulse closes the period with the old legality; the new
  // configuration takes effect from the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      p_act     <= PC_W'(2);
      legal_act <= 1'b0;
      div_pulse <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      div_pulse <= boundary & legal_act;
      if (boundary) begin
        p_act     <= new_p;
        legal_act <= new_legal;
        cfg_err   <= ~new_legal;
      end
    end
  end

endmodule

// File: rtl/dmfd_checker.sv
module dmfd_checker (
  input logic clk,
  input logic rst,
  input logic div_pulse,
  input logic cfg_err
);

  p_one_wide_r8: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && $past(cfg_err)) |-> !div_pulse);

  p_err_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |=> !div_pulse);

  p_err_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_err) |-> !div_pulse);

endmodule

bind dm_fb_divider dmfd_checker u_dmfd_checker (
  .clk       (clk),
  .rst       (rst),
  .div_pulse (div_pulse),
  .cfg_err   (cfg_err)
);

// File: tb/dm_fb_divider_bench.sv
`timescale 1ns/1ps
module dm_fb_divider_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  p_sel = 3'd0;
  logic [5:0]  a_cfg = 6'd0;
  logic [12:0] b_cfg = 13'd3;
  logic        div_pulse;
  logic        cfg_err;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  int    since = 0;
  int    e_val;
  string e_tag;
  logic  prev_pulse = 1'b0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  dm_fb_divider u_dm_fb_divider (
    .clk(clk), .rst(rst), .p_sel(p_sel), .a_cfg(a_cfg), .b_cfg(b_cfg),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  function automatic int n_of(int s, int a, int b);
    return (2 << s) * b + a;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: measures pulse spacing and scores it against the queue.
  always @(negedge clk) begin
    if (!rst) begin
      since++;
      if (div_pulse) begin
        check(!prev_pulse, "R8", int'(prev_pulse), 0);
        if (exp_q.size() > 0) begin
          e_val = exp_q.pop_front();
          e_tag = tag_q.pop_front();
          check(since == e_val, e_tag, since, e_val);
        end
        since = 0;
      end
      prev_pulse = div_pulse;
    end
  end

  task automatic set_cfg(int s, int a, int b);
    @(negedge clk);
    p_sel = 3'(s);
    a_cfg = 6'(a);
    b_cfg = 13'(b);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic run_case(int s, int a, int b, string tag);
    set_cfg(s, a, b);
    wait_pulse();
    @(negedge clk);
    exp_q.push_back(n_of(s, a, b)); tag_q.push_back(tag);
    exp_q.push_back(n_of(s, a, b)); tag_q.push_back(tag);
    drain();
  endtask

  // Starts from a legal running configuration (0,0,3), loads an illegal one,
  // then returns to a legal one and times the first pulse.
  task automatic illegal_case(int s, int a, int b, string tag);
    int pulses;
    int cnt;
    set_cfg(s, a, b);
    do @(negedge clk); while (!cfg_err);
    check(div_pulse == 1'b1, "R6", int'(div_pulse), 1);
    check(cfg_err == 1'b1, tag, int'(cfg_err), 1);
    pulses = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (div_pulse) pulses++;
      if (!cfg_err) pulses += 1000;
    end
    check(pulses == 0, "R7", pulses, 0);
    set_cfg(1, 2, 5);
    do @(negedge clk); while (cfg_err);
    check(div_pulse == 1'b0, "R7", int'(div_pulse), 0);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!div_pulse);
    check(cnt == n_of(1, 2, 5), "R7", cnt, n_of(1, 2, 5));
    run_case(0, 0, 3, "R1");
  endtask

  initial begin
    int bl[5] = '{1, 3, 4, 9, 64};
    int al[5] = '{0, 1, 2, 5, 63};
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R9", int'(div_pulse), 0);
    check(cfg_err == 1'b0, "R9", int'(cfg_err), 0);
    rst = 1'b0;

    run_case(0, 0, 3, "R3");
    run_case(4, 0, 3, "R2");
    run_case(2, 1, 4, "R1");

    // Sweep of every legal modulus with A and B values.
    for (int s = 0; s < 5; s++)
      for (int bi = 0; bi < 5; bi++)
        for (int ai = 0; ai < 5; ai++)
          if (bl[bi] > al[ai])
            run_case(s, al[ai], bl[bi], (al[ai] == 0) ? "R3" : "R1");

    // Mid-period change: old period keeps its length (R6).
    run_case(3, 2, 7, "R1");
    wait_pulse();
    @(negedge clk);
    exp_q.push_back(n_of(3, 2, 7)); tag_q.push_back("R6");
    exp_q.push_back(n_of(1, 3, 9)); tag_q.push_back("R6");
    repeat (2) @(negedge clk);
    p_sel = 3'd1; a_cfg = 6'd3; b_cfg = 13'd9;
    drain();
    run_case(0, 0, 3, "R1");

    illegal_case(0, 0, 0, "R4");
    illegal_case(1, 0, 2, "R4");
    illegal_case(2, 4, 4, "R5");
    illegal_case(3, 9, 5, "R5");
    illegal_case(5, 0, 3, "R2");
    illegal_case(7, 1, 4, "R2");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule